// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer Unit

This block sequences stack traffic for a small 8-bit processor. It keeps a 6-bit offset into a 64-byte stack window and forms a 13-bit RAM address by putting a fixed upper pattern above that offset. It drives address, write strobe, read strobe and write data toward an external RAM. It also reports the pointer, which always names the next free location.

Requests can be a single byte push or pull, a two-byte subroutine frame (call and return), or a five-byte interrupt frame (entry and return-from-interrupt). A frame moves one byte per clock, and `busy` and `done` frame the sequence. Each pulled byte comes out with a slot code that names the register it belongs to, so the datapath can route it.

The window has no overflow or underflow check. After 64 pushes the pointer comes back to the top of the window and older bytes are overwritten without any warning. A reset-stack request moves the pointer back to the top at any time, even in the middle of a frame.

Top module: `stack_window_unit`

## Requirements
- R1: Every address the block drives (`mem_addr`, `sp_addr`) has bits 12..6 equal to 0000011, so it lies in $00C0..$00FF; bits 5..0 are the stack offset.
- R2: After `rst_n` is low, and in the cycle after `rsp_req` is high, `sp_addr` is $00FF, `busy` and `done` are 0. An `rsp_req` aborts a running frame, and it suppresses `mem_we` and `mem_re` in the cycle where it is high.
- R3: Accepted requests follow a fixed priority: rsp_req > push_req > pull_req > call_req > ret_req > int_req > rti_req. Only one operation starts. Requests other than `rsp_req` are ignored while `busy` is 1.
- R4: A push access writes `mem_wdata` at `mem_addr == sp_addr` with `mem_we` = 1. In the next cycle the offset is one lower.
- R5: A pull access reads at offset+1 with `mem_re` = 1 and `pop_valid` = 1, and returns `mem_rdata` on `pop_data`. In the next cycle the offset is one higher.
- R6: The offset wraps modulo 64 in both directions with no flag: a push at $00C0 leaves the pointer at $00FF, and a pull from $00FF reads $00C0.
- R7: A call pushes PCL and then PCH. A return pulls PCH and then PCL. Slot codes: 0 = PCL, 1 = PCH, 2 = X, 3 = A, 4 = CC, 5 = single byte.
- R8: An interrupt entry pushes PCL, PCH, X, A, CC in that order. A return-from-interrupt pulls CC, A, X, PCH, PCL in that order.
- R9: An operation accepted at a clock edge has `busy` = 1 from the next cycle through its last access, one access per clock. `done` is a one-cycle pulse with `busy` = 0 in the cycle after the last access. Data inputs are sampled only at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_req | input | 1 | Reset-stack request |
| push_req | input | 1 | Single-byte push request |
| pull_req | input | 1 | Single-byte pull request |
| call_req | input | 1 | Two-byte call frame push |
| ret_req | input | 1 | Two-byte return frame pull |
| int_req | input | 1 | Five-byte interrupt frame push |
| rti_req | input | 1 | Five-byte interrupt frame pull |
| push_data | input | 8 | Byte for a single push |
| pcl_in | input | 8 | Program counter low byte |
| pch_in | input | 8 | Program counter high byte |
| x_in | input | 8 | Index register value |
| a_in | input | 8 | Accumulator value |
| cc_in | input | 8 | Condition code value |
| mem_rdata | input | 8 | RAM read data (same-cycle) |
| mem_addr | output | 13 | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 8 | RAM write data |
| pop_valid | output | 1 | Pulled byte valid |
| pop_slot | output | 3 | Register slot of pulled byte |
| pop_data | output | 8 | Pulled byte |
| sp_addr | output | 13 | Current pointer (next free location) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |

## Verification
Two situations are hard to reach from the ports: the silent wrap of the window, and a request that arrives while a frame is running. The bench pushes 70 single bytes so that the pointer crosses the bottom of the window and overwrites older bytes, and then pulls them back across the top. It also sweeps all 63 combinations of the six operation requests and holds them high for the whole frame. This checks both the priority pick and that nothing new starts while `busy` is 1. In a separate case, a reset-stack request arrives in the middle of an interrupt frame, and the bench checks the abort.

// File: rtl/stkw_pkg.sv
package stkw_pkg;

    localparam int SLOT_W = 3;
    localparam int NUM_OPS = 6;
    localparam int FRAME_N = 6;

    localparam logic [SLOT_W-1:0] SLOT_PCL  = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_PCH  = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_CC   = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_BYTE = 3'd5;

    // Request order doubles as priority order (index 0 wins)
    typedef enum logic [2:0] {
        K_PUSH1 = 3'd0,
        K_PULL1 = 3'd1,
        K_CALL  = 3'd2,
        K_RET   = 3'd3,
        K_INT   = 3'd4,
        K_RTI   = 3'd5
    } op_kind_e;

    function automatic logic [2:0] op_len(op_kind_e k);
        case (k)
            K_CALL, K_RET: return 3'd2;
            K_INT,  K_RTI: return 3'd5;
            default:       return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/stkw_req_arb.sv
module stkw_req_arb #(
    parameter int N = 6,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_vec,
    output logic          any_req,
    output logic [IW-1:0] pick
);
    // Lowest index has highest priority
    always_comb begin
        any_req = |req_vec;
        pick    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) pick = IW'(i);
        end
    end
endmodule

// File: rtl/stkw_slot_map.sv
module stkw_slot_map
    import stkw_pkg::*;
(
    input  op_kind_e          kind,
    input  logic [2:0]        idx,
    output logic [SLOT_W-1:0] slot,
    output logic              is_push
);
    always_comb begin
        slot    = SLOT_BYTE;
        is_push = 1'b0;
        case (kind)
            K_PUSH1: begin slot = SLOT_BYTE;        is_push = 1'b1; end
            K_PULL1: begin slot = SLOT_BYTE;        is_push = 1'b0; end
            K_CALL:  begin slot = SLOT_PCL + idx;   is_push = 1'b1; end
            K_RET:   begin slot = SLOT_PCH - idx;   is_push = 1'b0; end
            K_INT:   begin slot = SLOT_PCL + idx;   is_push = 1'b1; end
            K_RTI:   begin slot = SLOT_CC - idx;    is_push = 1'b0; end
            default: begin slot = SLOT_BYTE;        is_push = 1'b0; end
        endcase
    end
endmodule

// File: rtl/stkw_ptr_step.sv
module stkw_ptr_step #(
    parameter int OFS_W  = 6,
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-OFS_W-1:0] BASE_HI = 7'b0000011
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic              is_push,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [OFS_W-1:0]  ofs_next
);
    logic [OFS_W-1:0] ofs_up;
    logic [OFS_W-1:0] ofs_dn;

    always_comb begin
        ofs_up   = ofs + 1'b1;
        ofs_dn   = ofs - 1'b1;
        ptr_addr = {BASE_HI, ofs};
        // push writes at the free slot, pull reads the slot above it
        acc_addr = is_push ? {BASE_HI, ofs} : {BASE_HI, ofs_up};
        ofs_next = is_push ? ofs_dn : ofs_up;
    end
endmodule

// File: rtl/stack_window_unit.sv
module stack_window_unit
    import stkw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 6,
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-OFS_W-1:0] BASE_HI = 7'b0000011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_req,
    input  logic              push_req,
    input  logic              pull_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              int_req,
    input  logic              rti_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic [DATA_W-1:0] pcl_in,
    input  logic [DATA_W-1:0] pch_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] cc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pop_valid,
    output logic [SLOT_W-1:0] pop_slot,
    output logic [DATA_W-1:0] pop_data,
    output logic [ADDR_W-1:0] sp_addr,
    output logic              busy,
    output logic              done
);
    localparam int PICK_W = $clog2(NUM_OPS);

    typedef struct packed {
        logic [OFS_W-1:0]                ofs;
        logic                            busy;
        logic                            done;
        op_kind_e                        kind;
        logic [2:0]                      idx;
        logic [FRAME_N-1:0][DATA_W-1:0]  frame;
    } st_t;

    st_t st_q, st_d;

    logic [NUM_OPS-1:0] req_vec;
    logic               any_req;
    logic [PICK_W-1:0]  pick;
    logic [SLOT_W-1:0]  slot;
    logic               is_push;
    logic [ADDR_W-1:0]  ptr_addr;
    logic [ADDR_W-1:0]  acc_addr;
    logic [OFS_W-1:0]   ofs_next;
    logic               last_acc;

    assign req_vec = {rti_req, int_req, ret_req, call_req, pull_req, push_req};

    stkw_req_arb #(.N(NUM_OPS)) arb_i (
        .req_vec (req_vec),
        .any_req (any_req),
        .pick    (pick)
    );

    stkw_slot_map map_i (
        .kind    (st_q.kind),
        .idx     (st_q.idx),
        .slot    (slot),
        .is_push (is_push)
    );

    stkw_ptr_step #(
        .OFS_W   (OFS_W),
        .ADDR_W  (ADDR_W),
        .BASE_HI (BASE_HI)
    ) ptr_i (
        .ofs      (st_q.ofs),
        .is_push  (is_push),
        .ptr_addr (ptr_addr),
        .acc_addr (acc_addr),
        .ofs_next (ofs_next)
    );

    assign last_acc = (st_q.idx == op_len(st_q.kind) - 3'd1);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (rsp_req) begin
            st_d.ofs  = '1;
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end else if (st_q.busy) begin
            st_d.ofs = ofs_next;
            if (last_acc) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 3'd1;
            end
        end else if (any_req) begin
            st_d.busy  = 1'b1;
            st_d.kind  = op_kind_e'(pick);
            st_d.idx   = '0;
            st_d.frame = {push_data, cc_in, a_in, x_in, pch_in, pcl_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ofs   <= '1;
            st_q.kind  <= K_PUSH1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_we    = st_q.busy && is_push && !rsp_req;
        mem_re    = st_q.busy && !is_push && !rsp_req;
        mem_addr  = st_q.busy ? acc_addr : ptr_addr;
        mem_wdata = (slot < SLOT_W'(FRAME_N)) ? st_q.frame[slot] : '0;
        pop_valid = mem_re;
        pop_slot  = slot;
        pop_data  = mem_rdata;
        sp_addr   = ptr_addr;
        busy      = st_q.busy;
        done      = st_q.done;
    end

endmodule

// File: rtl/stack_window_chk.sv
module stack_window_chk #(
    parameter int OFS_W  = 6,
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-OFS_W-1:0] BASE_HI = 7'b0000011
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_req,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] sp_addr,
    input logic              busy,
    input logic              done
);
    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_addr[ADDR_W-1:OFS_W] == BASE_HI); // R1
    AST_RSP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_req |=> (sp_addr[OFS_W-1:0] == '1) && !busy && !done); // R2
    AST_RSP_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_req |-> !mem_we && !mem_re); // R2
    AST_PUSH_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_addr); // R4
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_addr[OFS_W-1:0] == OFS_W'($past(sp_addr[OFS_W-1:0]) - 1'b1)); // R4
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R4
    AST_PULL_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr[OFS_W-1:0] == OFS_W'(sp_addr[OFS_W-1:0] + 1'b1)); // R5
    AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_addr[OFS_W-1:0] == OFS_W'($past(sp_addr[OFS_W-1:0]) + 1'b1)); // R5
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && sp_addr[OFS_W-1:0] == '0) |=> sp_addr[OFS_W-1:0] == '1); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we && !mem_re); // R9
endmodule

bind stack_window_unit stack_window_chk #(
    .OFS_W   (OFS_W),
    .ADDR_W  (ADDR_W),
    .BASE_HI (BASE_HI)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_req  (rsp_req),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp_addr  (sp_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/stack_window_unit_tb.sv
module stack_window_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsp_req = 0, push_req = 0, pull_req = 0, call_req = 0;
    logic ret_req = 0, int_req = 0, rti_req = 0;
    logic [7:0] push_data = 0, pcl_in = 0, pch_in = 0, x_in = 0, a_in = 0, cc_in = 0;
    logic [7:0] mem_rdata;
    logic [12:0] mem_addr, sp_addr;
    logic mem_we, mem_re, pop_valid, busy, done;
    logic [7:0] mem_wdata, pop_data;
    logic [2:0] pop_slot;

    logic [7:0] ram [0:63];
    int shadow [0:63];
    int vals [0:5];
    int exp_ofs;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_window_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rsp_req(rsp_req), .push_req(push_req),
        .pull_req(pull_req), .call_req(call_req), .ret_req(ret_req),
        .int_req(int_req), .rti_req(rti_req), .push_data(push_data),
        .pcl_in(pcl_in), .pch_in(pch_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .pop_valid(pop_valid),
        .pop_slot(pop_slot), .pop_data(pop_data), .sp_addr(sp_addr),
        .busy(busy), .done(done)
    );

    assign mem_rdata = ram[mem_addr[5:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[5:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic set_reqs(input int mask);
        push_req = mask[0]; pull_req = mask[1]; call_req = mask[2];
        ret_req  = mask[3]; int_req  = mask[4]; rti_req  = mask[5];
    endtask

    task automatic load_vals(input int seed);
        for (int s = 0; s < 6; s++) vals[s] = (seed * 37 + s * 53 + 11) & 8'hFF;
    endtask

    // mask bit order = priority: push, pull, call, ret, int, rti (R3)
    task automatic run_op(input int mask, input bit hold);
        int k = 0;
        int len;
        int slot;
        bit is_push;
        for (int b = 5; b >= 0; b--) if (mask[b]) k = b;
        len = (k < 2) ? 1 : (k < 4) ? 2 : 5;
        is_push = (k % 2) == 0;
        @(negedge clk);
        pcl_in = vals[0]; pch_in = vals[1]; x_in = vals[2];
        a_in = vals[3]; cc_in = vals[4]; push_data = vals[5];
        set_reqs(mask);
        @(posedge clk); #1;
        // scramble inputs: only values at acceptance count (R9)
        pcl_in = ~pcl_in; pch_in = ~pch_in; x_in = ~x_in;
        a_in = ~a_in; cc_in = ~cc_in; push_data = ~push_data;
        if (!hold) set_reqs(0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            case (k)
                0, 1: slot = 5;
                2, 4: slot = i;
                3: slot = 1 - i;
                default: slot = 4 - i;
            endcase
            chk(busy == 1'b1, "R9 busy during frame", busy, 1);
            if (is_push) begin
                chk(mem_we && !mem_re, "R4 push strobe", {mem_we, mem_re}, 2);
                chk(mem_addr == (13'h0C0 | exp_ofs), "R4 R1 push addr", mem_addr, 13'h0C0 | exp_ofs);
                chk(mem_wdata == vals[slot], "R7 R8 push order", mem_wdata, vals[slot]);
                shadow[exp_ofs] = vals[slot];
                exp_ofs = (exp_ofs - 1) & 63;
            end else begin
                exp_ofs = (exp_ofs + 1) & 63;
                chk(mem_re && pop_valid && !mem_we, "R5 pull strobe", {mem_re, pop_valid, mem_we}, 6);
                chk(mem_addr == (13'h0C0 | exp_ofs), "R5 R6 pull addr", mem_addr, 13'h0C0 | exp_ofs);
                chk(pop_slot == slot, "R7 R8 pull slot order", pop_slot, slot);
                chk(pop_data == shadow[exp_ofs], "R5 pull data", pop_data, shadow[exp_ofs]);
            end
            if (hold && i == len - 1) set_reqs(0);
        end
        @(negedge clk);
        chk(done && !busy, "R9 done pulse", {done, busy}, 2);
        chk(sp_addr == (13'h0C0 | exp_ofs), "R3 R4 R5 pointer after op", sp_addr, 13'h0C0 | exp_ofs);
        @(negedge clk);
        chk(!done && !busy && !mem_we && !mem_re, "R9 idle after done", {done, busy}, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin ram[i] = 8'h00; shadow[i] = 0; end
        exp_ofs = 63;
        repeat (3) @(posedge clk);
        #1;
        chk(sp_addr == 13'h0FF && !busy && !done, "R2 reset state", sp_addr, 13'h0FF);
        rst_n = 1'b1;

        // wrap sweep: 70 single pushes cross the bottom (R6)
        for (int n = 0; n < 70; n++) begin
            load_vals(n);
            run_op(1, 1'b0);
        end
        chk(exp_ofs == ((63 - 70) & 63), "R6 bench model wrap", exp_ofs, (63 - 70) & 63);
        for (int n = 0; n < 70; n++) run_op(2, 1'b0);
        chk(sp_addr == 13'h0FF, "R6 pull back to top", sp_addr, 13'h0FF);

        // nested call / interrupt frames (R7 R8)
        for (int p = 0; p < 4; p++) begin
            load_vals(p + 100); run_op(4, 1'b0);
            load_vals(p + 200); run_op(16, 1'b0);
            load_vals(p + 300); run_op(4, 1'b0);
            run_op(8, 1'b0);
            run_op(32, 1'b0);
            run_op(8, 1'b0);
        end
        chk(sp_addr == 13'h0FF, "R7 R8 balanced frames", sp_addr, 13'h0FF);

        // priority sweep with requests held through busy (R3)
        for (int m = 1; m < 64; m++) begin
            load_vals(m);
            run_op(m, 1'b1);
        end

        // reset-stack with everything else requested (R2 R3)
        @(negedge clk);
        set_reqs(63); rsp_req = 1'b1;
        #1;
        chk(!mem_we && !mem_re, "R2 rsp mutes access", {mem_we, mem_re}, 0);
        @(posedge clk); #1;
        set_reqs(0); rsp_req = 1'b0;
        @(negedge clk);
        exp_ofs = 63;
        chk(sp_addr == 13'h0FF && !busy && !done, "R3 rsp wins", sp_addr, 13'h0FF);

        // reset-stack aborting an interrupt frame mid-way (R2)
        load_vals(7);
        @(negedge clk);
        int_req = 1'b1;
        @(posedge clk); #1; int_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b1 && sp_addr == 13'h0FE, "R2 frame running", sp_addr, 13'h0FE);
        rsp_req = 1'b1;
        #1;
        chk(!mem_we, "R2 rsp mutes push", mem_we, 0);
        @(posedge clk); #1; rsp_req = 1'b0;
        @(negedge clk);
        chk(sp_addr == 13'h0FF && !busy && !done, "R2 abort to top", sp_addr, 13'h0FF);

        // pull from top reads $C0 (R6)
        shadow[0] = ram[0];
        run_op(2, 1'b0);
        chk(sp_addr == 13'h0C0, "R6 pull wrap up", sp_addr, 13'h0C0);

        finish_run();
    end
endmodule